// File: doc/BRIEF.md
# ADC Power Sequencing Controller

This block is the host-side SPI master for a 12-bit multi-channel ADC that uses a fixed 16-clock frame. A client asks for a conversion by naming a channel and the power mode the converter should be left in. The controller keeps its own model of the converter's power state. From that state it decides which frames to send first: a wake-up frame when the converter is fully off, or a dummy frame with WRITE=0 when it is asleep between auto-shutdown conversions. It also holds back the next chip-select fall until the power-up or wake interval has passed. Only then does it run the real conversion frame.

Output from wake-up and dummy frames is always discarded. A real frame is reported as one `result_valid` pulse carrying the 3-bit channel tag and the 12-bit sample. If its leading bit is not zero, the frame is flagged with `frame_error` instead. A shutdown request sends a single control write. While a sequence runs, `busy` is high and new requests are ignored.

Top module: `adc_pwr_seq`

## Requirements
- R1: Each frame keeps `adc_cs_n` low for exactly 16 rising edges of `adc_sclk`. While `adc_cs_n` is high, `adc_sclk` is high, and both lines are high after reset.
- R2: `adc_mosi` changes only on a falling edge of `adc_sclk` or at the fall of `adc_cs_n`. The 12-bit control word is sent MSB first on the first 12 clocks, and the last 4 bits of the frame are zero.
- R3: Control word layout: bit 11 is WRITE, bits 10:8 are the channel, bits 7:6 are the power mode (11 normal, 01 auto shutdown, 10 full shutdown), and bits 5:0 are zero.
- R4: After reset the converter is assumed to be fully shut down. A conversion request from that state first sends a wake frame (WRITE=1, requested channel, mode 11). No result or error is reported for that frame.
- R5: After a wake frame, the next `adc_cs_n` fall comes at least PWRUP_CYC clocks after that frame's `adc_cs_n` rise.
- R6: When the converter sleeps after an auto-shutdown conversion, the next conversion request first sends an all-zero dummy word (WRITE=0), and its output is discarded. The following real frame's `adc_cs_n` fall comes at least WAKE_GAP_CYC clocks after the dummy frame's fall.
- R7: A real frame writes the requested channel and mode. Request mode 11 is normal, 01 is auto shutdown and 10 is full shutdown; 00 is treated as 11.
- R8: A full-shutdown request sends one write with mode 10 and reports nothing. The next conversion request then starts with a wake frame.
- R9: For a real frame whose first received bit is 0, `result_valid` pulses for one cycle with `result_chan` = received bits 14:12 and `result_data` = bits 11:0. If the first bit is 1, `frame_error` pulses instead. The two never pulse together.
- R10: `busy` is high from the cycle after an accepted request until the sequence ends. A request made while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_chan | input | 3 | Channel to convert |
| req_mode | input | 2 | Power mode to leave the converter in |
| busy | output | 1 | Sequence in progress |
| result_valid | output | 1 | One-cycle pulse for a good result |
| result_chan | output | 3 | Channel tag from the frame |
| result_data | output | 12 | Conversion sample |
| frame_error | output | 1 | Real frame with a nonzero leading bit |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_mosi | output | 1 | Serial data to the converter |
| adc_miso | input | 1 | Serial data from the converter |

## Verification
Directed requests walk through every pair of tracked power state and requested mode: off to normal, off with mode 00, on to auto, asleep to normal, asleep to auto, and shutdown from on. These cases separate a missing wake frame from a missing dummy frame or a wrong mode field. A randomly ordered mix of modes and channels then checks that the tracked state stays in step over long runs. A behavioural converter model in the bench measures the chip-select spacing in clock cycles and returns invalid words from sleeping frames, so a leaked dummy result or a short power-up wait shows up. A forced leading one on a real frame separates the error path from the result path, and requests made while busy confirm that they leave the frame sequence unchanged.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

    localparam int CTRL_W  = 12;
    localparam int FRAME_W = 16;

    localparam logic [1:0] PM_NORMAL = 2'b11;
    localparam logic [1:0] PM_AUTO   = 2'b01;
    localparam logic [1:0] PM_FULL   = 2'b10;

    typedef enum logic [1:0] {PW_OFF, PW_ON, PW_SLEEP} pwr_e;
    typedef enum logic [1:0] {FR_WAKE, FR_DUMMY, FR_REAL, FR_SDOWN} frame_e;
    typedef enum logic [1:0] {ST_IDLE, ST_LAUNCH, ST_WAIT} seq_e;

    typedef struct packed {
        seq_e        st;
        frame_e      kind;
        logic        need_wake;
        logic        need_dummy;
        logic        fin_real;
        logic [2:0]  ch;
        logic [1:0]  pm;
        pwr_e        pwr;
        logic        res_v;
        logic [2:0]  res_ch;
        logic [11:0] res_d;
        logic        err;
    } seq_t;

    function automatic logic [CTRL_W-1:0] ctrl_word(input logic wr,
                                                    input logic [2:0] ch,
                                                    input logic [1:0] pm);
        return {wr, ch, pm, 6'b000000};
    endfunction

endpackage

// File: rtl/adc_wait_timer.sv
module adc_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/adc_spi_frame.sv
module adc_spi_frame #(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [11:0] tx_word,
    input  logic        miso,
    output logic        ready,
    output logic        done,
    output logic [15:0] rx_word,
    output logic        cs_n,
    output logic        sclk,
    output logic        mosi
);
    localparam int DW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
    localparam logic [DW-1:0] DIV_TOP = DW'(HALF_DIV - 1);

    typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HIGH, PH_QUIET} ph_e;

    typedef struct packed {
        ph_e          ph;
        logic [DW-1:0] div;
        logic [4:0]   bitn;
        logic [15:0]  tx;
        logic [15:0]  rx;
        logic         cs_n;
        logic         sclk;
        logic         mosi;
        logic         done;
    } eng_t;

    eng_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.ph)
            PH_IDLE: if (start) begin
                d.ph   = PH_SETUP;
                d.cs_n = 1'b0;
                d.tx   = {tx_word, 4'b0000};
                d.mosi = tx_word[11];
                d.div  = DIV_TOP;
                d.bitn = '0;
            end
            PH_SETUP: if (q.div == '0) begin
                d.ph   = PH_LOW;
                d.sclk = 1'b0;
                d.div  = DIV_TOP;
            end else d.div = q.div - DW'(1);
            PH_LOW: if (q.div == '0) begin
                d.ph   = PH_HIGH;
                d.sclk = 1'b1;
                d.rx   = {q.rx[14:0], miso};
                d.bitn = q.bitn + 5'd1;
                d.div  = DIV_TOP;
            end else d.div = q.div - DW'(1);
            PH_HIGH: if (q.div == '0) begin
                d.div = DIV_TOP;
                if (q.bitn == 5'd16) begin
                    d.ph   = PH_QUIET;
                    d.cs_n = 1'b1;
                    d.mosi = 1'b0;
                    d.done = 1'b1;
                end else begin
                    d.ph   = PH_LOW;
                    d.sclk = 1'b0;
                    d.tx   = {q.tx[14:0], 1'b0};
                    d.mosi = q.tx[14];
                end
            end else d.div = q.div - DW'(1);
            PH_QUIET: if (q.div == '0) d.ph = PH_IDLE;
                      else d.div = q.div - DW'(1);
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ph   <= PH_IDLE;
            q.cs_n <= 1'b1;
            q.sclk <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ready   = (q.ph == PH_IDLE);
    assign done    = q.done;
    assign rx_word = q.rx;
    assign cs_n    = q.cs_n;
    assign sclk    = q.sclk;
    assign mosi    = q.mosi;
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
    import adc_pwr_pkg::*;
#(
    parameter int HALF_DIV     = 2,
    parameter int PWRUP_CYC    = 100,
    parameter int WAKE_GAP_CYC = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [2:0]  req_chan,
    input  logic [1:0]  req_mode,
    output logic        busy,
    output logic        result_valid,
    output logic [2:0]  result_chan,
    output logic [11:0] result_data,
    output logic        frame_error,
    output logic        adc_cs_n,
    output logic        adc_sclk,
    output logic        adc_mosi,
    input  logic        adc_miso
);
    localparam int WMAX = (PWRUP_CYC > WAKE_GAP_CYC) ? PWRUP_CYC : WAKE_GAP_CYC;
    localparam int TW   = $clog2(WMAX + 2);

    seq_t d, q;

    logic              eng_start, eng_ready, eng_done;
    logic [CTRL_W-1:0] eng_tx;
    logic [15:0]       eng_rx;
    logic              t_load, t_zero;
    logic [TW-1:0]     t_val;
    frame_e            sel;
    logic [1:0]        mode_n;

    adc_spi_frame #(.HALF_DIV(HALF_DIV)) u_frame (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .tx_word(eng_tx),
        .miso(adc_miso), .ready(eng_ready), .done(eng_done), .rx_word(eng_rx),
        .cs_n(adc_cs_n), .sclk(adc_sclk), .mosi(adc_mosi)
    );

    adc_wait_timer #(.W(TW)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
    );

    always_comb begin
        d         = q;
        d.res_v   = 1'b0;
        d.err     = 1'b0;
        eng_start = 1'b0;
        t_load    = 1'b0;
        t_val     = '0;
        mode_n    = (req_mode == 2'b00) ? PM_NORMAL : req_mode;

        if (q.need_wake)       sel = FR_WAKE;
        else if (q.need_dummy) sel = FR_DUMMY;
        else if (q.fin_real)   sel = FR_REAL;
        else                   sel = FR_SDOWN;

        case (sel)
            FR_WAKE:  eng_tx = ctrl_word(1'b1, q.ch, PM_NORMAL);
            FR_DUMMY: eng_tx = '0;
            FR_REAL:  eng_tx = ctrl_word(1'b1, q.ch, q.pm);
            default:  eng_tx = ctrl_word(1'b1, q.ch, PM_FULL);
        endcase

        case (q.st)
            ST_IDLE: if (req_valid) begin
                d.st = ST_LAUNCH;
                d.ch = req_chan;
                d.pm = mode_n;
                if (mode_n == PM_FULL) begin
                    d.need_wake  = 1'b0;
                    d.need_dummy = 1'b0;
                    d.fin_real   = 1'b0;
                end else begin
                    d.need_wake  = (q.pwr == PW_OFF);
                    d.need_dummy = (q.pwr == PW_SLEEP);
                    d.fin_real   = 1'b1;
                end
            end
            ST_LAUNCH: if (eng_ready && t_zero) begin
                eng_start = 1'b1;
                d.kind    = sel;
                d.st      = ST_WAIT;
                if (sel == FR_DUMMY) begin
                    t_load = 1'b1;
                    t_val  = TW'(WAKE_GAP_CYC);
                end
            end
            ST_WAIT: if (eng_done) begin
                case (q.kind)
                    FR_WAKE: begin
                        d.need_wake = 1'b0;
                        d.pwr       = PW_ON;
                        d.st        = ST_LAUNCH;
                        t_load      = 1'b1;
                        t_val       = TW'(PWRUP_CYC);
                    end
                    FR_DUMMY: begin
                        d.need_dummy = 1'b0;
                        d.pwr        = PW_ON;
                        d.st         = ST_LAUNCH;
                    end
                    FR_REAL: begin
                        d.st     = ST_IDLE;
                        d.pwr    = (q.pm == PM_AUTO) ? PW_SLEEP : PW_ON;
                        d.res_ch = eng_rx[14:12];
                        d.res_d  = eng_rx[11:0];
                        d.res_v  = ~eng_rx[15];
                        d.err    = eng_rx[15];
                    end
                    default: begin
                        d.st  = ST_IDLE;
                        d.pwr = PW_OFF;
                    end
                endcase
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.pwr <= PW_OFF;
        end else begin
            q <= d;
        end
    end

    assign busy         = (q.st != ST_IDLE);
    assign result_valid = q.res_v;
    assign result_chan  = q.res_ch;
    assign result_data  = q.res_d;
    assign frame_error  = q.err;
endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [2:0]  req_chan,
    input logic [1:0]  req_mode,
    input logic        busy,
    input logic        result_valid,
    input logic [2:0]  result_chan,
    input logic [11:0] result_data,
    input logic        frame_error,
    input logic        adc_cs_n,
    input logic        adc_sclk,
    input logic        adc_mosi,
    input logic        adc_miso
);
    // R1
    sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> adc_sclk);

    // R2
    mosi_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_cs_n && $past(!adc_cs_n) && !$fell(adc_sclk)) |-> $stable(adc_mosi));

    // R9
    result_xor_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(result_valid && frame_error));

    // R9
    result_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R10
    idle_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> adc_cs_n);

    // R10
    busy_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
endmodule

bind adc_pwr_seq adc_pwr_seq_chk u_chk (.*);

// File: tb/adc_pwr_seq_tb.sv
module adc_pwr_seq_tb;
    localparam int HALF = 2;
    localparam int PWRUP = 100;
    localparam int GAP = 100;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_chan = '0;
    logic [1:0] req_mode = '0;
    logic busy, result_valid, frame_error, cs_n, sclk, mosi;
    logic miso = 1'b1;
    logic [2:0] result_chan;
    logic [11:0] result_data;

    always #5 clk = ~clk;

    adc_pwr_seq #(.HALF_DIV(HALF), .PWRUP_CYC(PWRUP), .WAKE_GAP_CYC(GAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
        .req_mode(req_mode), .busy(busy), .result_valid(result_valid),
        .result_chan(result_chan), .result_data(result_data),
        .frame_error(frame_error), .adc_cs_n(cs_n), .adc_sclk(sclk),
        .adc_mosi(mosi), .adc_miso(miso)
    );

    int checks = 0, fails = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // converter model: 0 off, 1 on, 2 asleep, 3 waking, 4 after dummy
    int m_st = 0, wake_t = 0, dummy_t = 0, viol = 0, conv_n = 0;
    logic [2:0] m_addr = '0;
    logic [1:0] m_pm = 2'b10;
    logic [15:0] out_w = '0, rx_w = '0, sent_w = '0;
    int rises = 0;
    logic p_cs = 1'b1, p_sclk = 1'b1;
    bit inj_err = 0, was_asleep = 0;
    logic [15:0] fr_word [8];
    int fr_rises [8];
    int fr_cnt = 0;
    int res_n = 0, err_n = 0;
    logic [14:0] res_w = '0;

    always @(negedge clk) begin
        if (result_valid) begin res_n++; res_w = {result_chan, result_data}; end
        if (frame_error) err_n++;
        if (p_cs && !cs_n) begin
            rises = 0; rx_w = '0; was_asleep = (m_st == 2);
            if (m_st == 3 && cyc - wake_t < PWRUP) viol++;
            if (m_st == 4 && cyc - dummy_t < GAP) viol++;
            if (m_st == 0 || m_st == 2) begin
                out_w = 16'hFFFF;
                if (m_st == 2) dummy_t = cyc;
            end else begin
                conv_n++;
                out_w = {1'b0, m_addr, 12'(conv_n * 173 + 5)};
                if (inj_err) begin out_w[15] = 1'b1; inj_err = 0; end
                sent_w = out_w;
            end
            miso = out_w[15];
        end else if (!cs_n) begin
            if (!p_sclk && sclk) begin rx_w = {rx_w[14:0], mosi}; rises++; end
            if (p_sclk && !sclk && rises > 0 && rises < 16) miso = out_w[15 - rises];
        end
        if (!p_cs && cs_n) begin
            if (fr_cnt < 8) begin fr_word[fr_cnt] = rx_w; fr_rises[fr_cnt] = rises; end
            fr_cnt++;
            if (rises == 16 && rx_w[15]) begin
                m_addr = rx_w[14:12];
                if (m_st == 0 && rx_w[11:10] == 2'b11) begin m_st = 3; wake_t = cyc; end
                m_pm = rx_w[11:10];
            end
            if (m_pm == 2'b10) m_st = 0;
            else if (m_st == 0 || m_st == 3) m_st = (m_st == 3 && m_pm == 2'b01) ? 2 : m_st;
            else if (was_asleep) m_st = 4;
            else m_st = (m_pm == 2'b01) ? 2 : 1;
            miso = 1'b1;
        end
        p_cs = cs_n; p_sclk = sclk;
    end

    // bench model of expected frames
    int e_pwr = 0;            // 0 off, 1 on, 2 asleep
    logic [2:0] e_addr = '0;
    logic [11:0] e_w [4];
    int e_n, e_real;
    logic [2:0] e_tag;

    task automatic plan(input logic [2:0] ch, input logic [1:0] md);
        logic [1:0] m;
        m = (md == 2'b00) ? 2'b11 : md;
        e_n = 0; e_real = -1;
        if (m == 2'b10) begin
            e_w[0] = {1'b1, ch, 2'b10, 6'b0}; e_n = 1; e_pwr = 0; e_addr = ch;
        end else begin
            if (e_pwr == 0) begin e_w[e_n] = {1'b1, ch, 2'b11, 6'b0}; e_n++; e_addr = ch; end
            if (e_pwr == 2) begin e_w[e_n] = 12'h000; e_n++; end
            e_tag = e_addr; e_real = e_n;
            e_w[e_n] = {1'b1, ch, m, 6'b0}; e_n++; e_addr = ch;
            e_pwr = (m == 2'b01) ? 2 : 1;
        end
    endtask

    bit hung = 0;

    task automatic request(input logic [2:0] ch, input logic [1:0] md,
                           input bit err, input bit spur);
        int n;
        fr_cnt = 0; res_n = 0; err_n = 0; inj_err = err;
        plan(ch, md);
        @(negedge clk);
        req_valid = 1'b1; req_chan = ch; req_mode = md;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R10 busy after accept", busy, 1);
        if (spur) begin
            repeat (5) @(negedge clk);
            req_valid = 1'b1; req_chan = ~ch; req_mode = 2'b10;
            @(negedge clk);
            req_valid = 1'b0;
        end
        n = 0;
        while (busy && n < 20000) begin @(negedge clk); n++; end
        if (busy) begin hung = 1; check(0, "R10 watchdog", 1, 0); return; end
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R10 stays idle after ignored request", busy, 0);
        check(fr_cnt == e_n, "R4 R6 R8 frame count", fr_cnt, e_n);
        for (int i = 0; i < e_n && i < fr_cnt && i < 8; i++) begin
            check(fr_word[i][15:4] == e_w[i], "R3 R7 control word", fr_word[i][15:4], e_w[i]);
            check(fr_word[i][3:0] == 4'h0, "R2 trailing bits", fr_word[i][3:0], 0);
            check(fr_rises[i] == 16, "R1 clocks per frame", fr_rises[i], 16);
        end
        if (e_real < 0) begin
            check(res_n == 0 && err_n == 0, "R8 no report for shutdown", res_n + err_n, 0);
        end else if (err) begin
            check(res_n == 0 && err_n == 1, "R9 leading one flagged", err_n, 1);
        end else begin
            check(res_n == 1 && err_n == 0, "R9 one result per request", res_n, 1);
            check(res_w == sent_w[14:0], "R9 result word", res_w, sent_w[14:0]);
            check(res_w[14:12] == e_tag, "R9 channel tag", res_w[14:12], e_tag);
        end
        check(viol == 0, "R5 R6 wait spacing", viol, 0);
    endtask

    initial begin
        void'($urandom(32'd4321));
        repeat (4) @(negedge clk);
        check(cs_n == 1'b1 && sclk == 1'b1, "R1 reset lines", {cs_n, sclk}, 3);
        check(busy == 1'b0 && result_valid == 1'b0, "R10 reset idle", busy, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        request(3'd5, 2'b11, 0, 0);   // R4 off -> wake + real
        request(3'd2, 2'b01, 0, 1);   // R7 on -> auto
        request(3'd3, 2'b11, 0, 0);   // R6 asleep -> dummy + normal
        request(3'd1, 2'b01, 0, 0);
        request(3'd6, 2'b01, 0, 1);   // R6 asleep -> dummy + auto
        request(3'd0, 2'b10, 0, 0);   // R8 shutdown from asleep
        request(3'd4, 2'b00, 0, 0);   // R7 mode 00 as normal, R4 wake
        request(3'd7, 2'b11, 1, 0);   // R9 leading one
        request(3'd2, 2'b10, 0, 0);   // R8
        request(3'd1, 2'b01, 0, 0);   // R4 wake then auto
        for (int k = 0; k < 40 && !hung; k++) begin
            logic [1:0] md;
            md = 2'($urandom_range(0, 3));
            request(3'($urandom_range(0, 7)), md, ($urandom_range(0, 9) == 0), ($urandom_range(0, 3) == 0));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1900000;
        fails++; checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule